// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregator

The block gathers up to 24 interrupt request lines into one interrupt output for a host processor. Each request line has a detection mode chosen by two configuration words: level, rising edge, falling edge, or both edges. A detected event sets a sticky pending bit. That bit stays set until software writes a 1 to it.

An enable mask selects which pending bits may raise the host interrupt. The mask can be written directly, or changed bit by bit through a set alias address and a clear alias address. An identity word reports the pending bits that are also enabled. The output `irq_o` is high whenever at least one identity bit is set.

Software uses a plain 32-bit register bus with address, write enable, write data and registered read data. All offsets below are byte offsets on `reg_addr_i`.

Top module: `irq_aggregator`

## Requirements
- R1: Only bits 0 to 23 hold state. Bit n belongs to source n. Bits 31:24 of every read return 0, and writes to them have no effect.
- R2: Offset 0x10 reads the sticky pending bits. A write there clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A write to offset 0x18 replaces the whole enable mask, and a read there returns the mask.
- R4: A write to offset 0x1c clears only the enable bits written as 1. A write to offset 0x20 sets only the enable bits written as 1. Reads of both offsets return 0.
- R5: Offset 0x38 reads as sticky AND enable. Offset 0x3c, any other identity offset and any other unmapped offset read as 0.
- R6: Trigger words sit at 0x5c (word A) and 0x60 (word B) and read back as written. Source n's mode is {B[n],A[n]}: 00 is level, 01 is rising edge, 10 is falling edge, 11 is either edge.
- R7: A level source sets its sticky bit at every clock edge at which its input is high.
- R8: An edge source sets its sticky bit only at the clock edge where its input shows the selected transition relative to the previous edge. The previous value is 0 after reset.
- R9: When a hardware set and a software clear hit the same sticky bit in the same cycle, the bit ends up set.
- R10: `irq_o` is a register equal to the OR of the identity bits. It rises at the same clock edge that sets an enabled sticky bit, one cycle after the input is presented. It falls at the edge that clears the last enabled pending bit or disables it.
- R11: After reset, every register reads 0 and `irq_o` is low.
- R12: Read data appears on `reg_rdata_o` at the clock edge after the address is presented. It reflects the state before any write accepted at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 24 | Interrupt request lines |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
A wrong detection mode or a lost previous-input value shows up as a sticky bit that is wrongly set or missing. It can be read at offset 0x10 or 0x38 in the cycle after the stimulus edge. `irq_o` reflects the same fault at that same edge.

The bench steps every source through all four trigger modes with a rise, a software clear while high, and a fall. A corrupted enable or alias path shows up in the next readback of offset 0x18 and in `irq_o`.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam logic [7:0] OFS_STICKY  = 8'h10;
  localparam logic [7:0] OFS_ENA     = 8'h18;
  localparam logic [7:0] OFS_ENA_CLR = 8'h1c;
  localparam logic [7:0] OFS_ENA_SET = 8'h20;
  localparam logic [7:0] OFS_IDENT0  = 8'h38;
  localparam logic [7:0] OFS_TRIG_A  = 8'h5c;
  localparam logic [7:0] OFS_TRIG_B  = 8'h60;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] trig_a_i,
  input  logic [NUM_SRC-1:0] trig_b_i,
  output logic [NUM_SRC-1:0] hit_o,
  output logic [NUM_SRC-1:0] prev_o
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic       rise, fall;
    trig_mode_e mode;
    assign rise = irq_i[i] & ~prev_q[i];
    assign fall = ~irq_i[i] & prev_q[i];
    assign mode = trig_mode_e'({trig_b_i[i], trig_a_i[i]});
    always_comb begin
      unique case (mode)
        TRIG_LEVEL: hit_o[i] = irq_i[i];
        TRIG_RISE:  hit_o[i] = rise;
        TRIG_FALL:  hit_o[i] = fall;
        default:    hit_o[i] = rise | fall;
      endcase
    end
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/irq_agg_cfg.sv
module irq_agg_cfg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned AW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] en_nxt_o,
  output logic [NUM_SRC-1:0] trig_a_o,
  output logic [NUM_SRC-1:0] trig_b_o
);
  logic [NUM_SRC-1:0] en_q, en_d, trig_a_q, trig_b_q;

  always_comb begin
    en_d = en_q;
    if (we_i) begin
      if (addr_i == AW'(OFS_ENA))          en_d = wdata_i;
      else if (addr_i == AW'(OFS_ENA_CLR)) en_d = en_q & ~wdata_i;
      else if (addr_i == AW'(OFS_ENA_SET)) en_d = en_q | wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      trig_a_q <= '0;
      trig_b_q <= '0;
    end else begin
      en_q <= en_d;
      if (we_i && addr_i == AW'(OFS_TRIG_A)) trig_a_q <= wdata_i;
      if (we_i && addr_i == AW'(OFS_TRIG_B)) trig_b_q <= wdata_i;
    end
  end

  assign en_o     = en_q;
  assign en_nxt_o = en_d;
  assign trig_a_o = trig_a_q;
  assign trig_b_o = trig_b_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] wdata_s, hit, irq_prev;
  logic [NUM_SRC-1:0] en_q, en_d, trig_a_q, trig_b_q;
  logic [NUM_SRC-1:0] sticky_q, sticky_d, sticky_clr;
  logic [DW-1:0]      rdata_q, rdata_d;
  logic               irq_q;

  assign wdata_s = reg_wdata_i[NUM_SRC-1:0];

  if (NUM_SRC < DW) begin : g_unused
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata_i[DW-1:NUM_SRC];
  end

  irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .trig_a_i (trig_a_q),
    .trig_b_i (trig_b_q),
    .hit_o    (hit),
    .prev_o   (irq_prev)
  );

  irq_agg_cfg #(.NUM_SRC(NUM_SRC), .AW(AW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (wdata_s),
    .en_o     (en_q),
    .en_nxt_o (en_d),
    .trig_a_o (trig_a_q),
    .trig_b_o (trig_b_q)
  );

  // hardware set takes priority over write-1-to-clear
  assign sticky_clr = (reg_we_i && reg_addr_i == AW'(OFS_STICKY)) ? wdata_s : '0;
  assign sticky_d   = (sticky_q & ~sticky_clr) | hit;

  always_comb begin
    rdata_d = '0;
    unique case (reg_addr_i)
      AW'(OFS_STICKY): rdata_d[NUM_SRC-1:0] = sticky_q;
      AW'(OFS_ENA):    rdata_d[NUM_SRC-1:0] = en_q;
      AW'(OFS_IDENT0): rdata_d[NUM_SRC-1:0] = sticky_q & en_q;
      AW'(OFS_TRIG_A): rdata_d[NUM_SRC-1:0] = trig_a_q;
      AW'(OFS_TRIG_B): rdata_d[NUM_SRC-1:0] = trig_b_q;
      default:         rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      rdata_q  <= rdata_d;
      irq_q    <= |(sticky_d & en_d);
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic               reg_we_i,
  input logic [DW-1:0]      reg_wdata_i,
  input logic [DW-1:0]      reg_rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] sticky_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] trig_a_q,
  input logic [NUM_SRC-1:0] trig_b_q,
  input logic [NUM_SRC-1:0] prev_q
);
  logic [NUM_SRC-1:0] lvl_req, clr_req, wlo;
  assign wlo     = reg_wdata_i[NUM_SRC-1:0];
  assign lvl_req = irq_i & ~(trig_a_q | trig_b_q);
  assign clr_req = (reg_we_i && reg_addr_i == AW'(OFS_STICKY)) ? wlo : '0;

  AST_RDATA_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DW-1:NUM_SRC] == '0); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sticky_q) & ~$past(clr_req) & ~sticky_q) == '0)); // R2

  AST_ENA_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(OFS_ENA_SET)) |=> ((en_q & $past(wlo)) == $past(wlo))); // R4

  AST_ENA_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(OFS_ENA_CLR)) |=> ((en_q & $past(wlo)) == '0)); // R4

  AST_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_req != '0) |=> ((sticky_q & $past(lvl_req)) == $past(lvl_req))); // R7

  AST_NO_CAUSELESS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_q & ~$past(sticky_q) & ~$past(irq_i | prev_q)) == '0)); // R8

  AST_IRQ_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(sticky_q & en_q)); // R10
endmodule

bind irq_aggregator irq_agg_checker #(.NUM_SRC(NUM_SRC), .DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .sticky_q    (sticky_q),
  .en_q        (en_q),
  .trig_a_q    (trig_a_q),
  .trig_b_q    (trig_b_q),
  .prev_q      (irq_prev)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  localparam logic [7:0] A_STK = 8'h10, A_ENA = 8'h18, A_CLR = 8'h1c, A_SET = 8'h20;
  localparam logic [7:0] A_ID0 = 8'h38, A_ID1 = 8'h3c, A_TRA = 8'h5c, A_TRB = 8'h60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); #1; d = rdata;
  endtask

  task automatic drive_irq(input logic [23:0] v);
    @(negedge clk); irq = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, bitv, exp_v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11 reset state
    rd(A_STK, v); check("R11 sticky", v, 0);
    rd(A_ENA, v); check("R11 enable", v, 0);
    rd(A_ID0, v); check("R11 ident", v, 0);
    rd(A_TRA, v); check("R11 trig A", v, 0);
    rd(A_TRB, v); check("R11 trig B", v, 0);
    check("R11 irq_o", {31'b0, irq_out}, 0);

    // R3 direct enable, R1 upper bits
    wr(A_ENA, 32'h00a5_a5a5); rd(A_ENA, v); check("R3 enable write", v, 32'h00a5_a5a5);
    wr(A_ENA, 32'h0);         rd(A_ENA, v); check("R3 enable zero", v, 0);
    wr(A_ENA, 32'hffff_ffff); rd(A_ENA, v); check("R1 enable upper ignored", v, 32'h00ff_ffff);

    // R4 aliases
    wr(A_CLR, 32'h0000_f00f); rd(A_ENA, v); check("R4 clear alias", v, 32'h00ff_0ff0);
    wr(A_SET, 32'h0f00_000f); rd(A_ENA, v); check("R4 set alias", v, 32'h00ff_0fff);
    rd(A_CLR, v); check("R4 clear alias reads 0", v, 0);
    rd(A_SET, v); check("R4 set alias reads 0", v, 0);

    // R6 trigger readback
    wr(A_TRA, 32'hffff_ffff); rd(A_TRA, v); check("R6 trig A readback", v, 32'h00ff_ffff);
    wr(A_TRB, 32'h0012_3456); rd(A_TRB, v); check("R6 trig B readback", v, 32'h0012_3456);
    wr(A_TRA, 0); wr(A_TRB, 0);

    // R5 identity, R2 write-1-to-clear, R10 output level
    wr(A_ENA, 32'h0000_0f0f);
    drive_irq(24'h00ff00); drive_irq(24'h0);
    rd(A_STK, v); check("R7 level latched", v, 32'h0000_ff00);
    rd(A_ID0, v); check("R5 ident and", v, 32'h0000_0f00);
    check("R10 irq_o high", {31'b0, irq_out}, 1);
    rd(A_ID1, v); check("R5 ident dst1 zero", v, 0);
    rd(8'h44, v); check("R5 unmapped 0x44", v, 0);
    rd(8'h00, v); check("R5 unmapped 0x00", v, 0);
    wr(A_ENA, 32'h0000_00ff);
    check("R10 irq_o drops on disable", {31'b0, irq_out}, 0);
    wr(A_STK, 32'h0000_0f00); rd(A_STK, v); check("R2 partial clear", v, 32'h0000_f000);
    wr(A_STK, 32'h0); rd(A_STK, v); check("R2 zero write keeps", v, 32'h0000_f000);
    wr(A_STK, 32'hffff_ffff); rd(A_STK, v); check("R2 clear all", v, 0);

    // R12 latency: value changes only at the edge after the address
    wr(A_STK, 32'hffff_ffff);
    wr(A_ENA, 32'h0000_0033);
    rd(A_ENA, v);
    @(negedge clk); addr = A_TRB; #1;
    check("R12 rdata held before edge", rdata, 32'h0000_0033);
    @(posedge clk); #1;
    check("R12 rdata after edge", rdata, 0);

    // R10 timing: rises at first edge after input presented
    wr(A_ENA, 32'h00ff_ffff);
    @(negedge clk); irq = 24'h000008; #1;
    check("R10 irq_o before edge", {31'b0, irq_out}, 0);
    @(posedge clk); #1;
    check("R10 irq_o at edge", {31'b0, irq_out}, 1);
    drive_irq(0);
    wr(A_STK, 32'hffff_ffff);
    check("R10 irq_o after ack", {31'b0, irq_out}, 0);

    // R9 edge set coincides with clear
    wr(A_TRA, 32'h0000_0020);
    @(negedge clk); irq = 24'h000020; addr = A_STK; we = 1'b1; wdata = 32'h20;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(A_STK, v); check("R9 set wins over clear", v, 32'h0000_0020);
    drive_irq(0);
    wr(A_STK, 32'hffff_ffff);
    wr(A_TRA, 0);

    // R7/R8/R9 sweep: every source in every mode
    for (int s = 0; s < 24; s++) begin
      for (int m = 0; m < 4; m++) begin
        bitv = 32'h1 << s;
        wr(A_TRA, (m & 1) ? bitv : 32'h0);
        wr(A_TRB, (m & 2) ? bitv : 32'h0);
        wr(A_STK, 32'hffff_ffff);
        rd(A_STK, v); check("R8 idle clear", v, 0);
        drive_irq(bitv[23:0]);
        rd(A_STK, v); exp_v = (m != 2) ? bitv : 0;
        check((m == 0) ? "R7 level high" : "R8 rise phase", v, exp_v);
        check("R10 irq_o rise phase", {31'b0, irq_out}, {31'b0, exp_v != 0});
        wr(A_STK, bitv);
        rd(A_STK, v); exp_v = (m == 0) ? bitv : 0;
        check((m == 0) ? "R9 level reasserts over clear" : "R8 edge held cleared", v, exp_v);
        drive_irq(24'h0);
        rd(A_ID0, v); exp_v = (m != 1) ? bitv : 0;
        check("R8 fall phase ident", v, exp_v);
        check("R10 irq_o fall phase", {31'b0, irq_out}, {31'b0, exp_v != 0});
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule